// File: doc/BRIEF.md
# Sub-word result merge unit

This writeback stage builds the full-width value that goes into a destination physical register when an ALU produced a byte or a word result. The low part always comes from the ALU result. The bits above the operation size come from one of four sources, chosen per operation: the old contents of the destination, the first source operand, all zeros, or copies of the result's top bit. A long operation writes the result unchanged.

A renaming core uses it in one of two ways. The preserve policy keeps the classic partial-register semantics, but it needs the old destination value as an extra read. The other policies avoid that read. The first-source policy makes a three-operand operation produce the same full value that the two-operand form would have produced with that source as its destination. The merged value is registered, so it appears one cycle after the request together with a valid flag.

Top module: `subword_merge`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after reset, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals the value `in_valid` had one clock earlier.
- R3: Byte size (`size`=00) with preserve policy (`policy`=00): `out_data[7:0]` is `res[7:0]` and `out_data[31:8]` is `old_dst[31:8]`.
- R4: Word size (`size`=01) with preserve policy: `out_data[15:0]` is `res[15:0]` and `out_data[31:16]` is `old_dst[31:16]`.
- R5: First-source policy (`policy`=01): the bits above the operation size (bit 8 for byte, bit 16 for word) come from `src1`, and the low bits come from `res`.
- R6: Zero policy (`policy`=10): the bits above the operation size are 0, whatever `old_dst` holds.
- R7: Sign policy (`policy`=11): the bits above the operation size copy `res[7]` for byte size and `res[15]` for word size.
- R8: Long size (`size`=10), and the unused code 11, pass `res` through unchanged whatever the policy.
- R9: A cycle with `in_valid` low leaves `out_data` at its previous value, whatever the other inputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | A merge request is present this cycle |
| res | input | 32 | Raw ALU result |
| old_dst | input | 32 | Previous value of the destination register |
| src1 | input | 32 | First source operand value |
| size | input | 2 | Operation size: 00 byte, 01 word, 10 long, 11 treated as long |
| policy | input | 2 | Upper-bit source: 00 preserve, 01 first source, 10 zero, 11 sign |
| out_data | output | 32 | Merged register value, registered |
| out_valid | output | 1 | `out_data` holds a new merge result |

## Verification
The bench builds the block with its default 32-bit width. The byte boundary is then bit 8 and the word boundary is bit 16. At this width every pairing of the four policies with the four size codes can be driven, and the reference model checks each one against its own mask arithmetic. The chosen values put a set top bit right at each boundary, for the sign policy, and an old destination value that differs from the first source. A wrong upper source therefore always changes the output. Idle cycles with changing inputs are mixed into the stream to show that the registered value is held.

// File: rtl/subword_merge.sv
module subword_merge #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_valid,
  input  logic [W-1:0] res,
  input  logic [W-1:0] old_dst,
  input  logic [W-1:0] src1,
  input  logic [1:0]   size,
  input  logic [1:0]   policy,
  output logic [W-1:0] out_data,
  output logic         out_valid
);
  localparam int BW = W / 4;
  localparam int HW = W / 2;

  logic [W-1:0] fill_byte, fill_word, upper_src, merged;

  assign fill_byte = {W{res[BW-1]}};
  assign fill_word = {W{res[HW-1]}};

  always_comb begin
    case (policy)
      2'b00:   upper_src = old_dst;
      2'b01:   upper_src = src1;
      2'b10:   upper_src = '0;
      default: upper_src = (size == 2'b00) ? fill_byte : fill_word;
    endcase
  end

  always_comb begin
    case (size)
      2'b00:   merged = {upper_src[W-1:BW], res[BW-1:0]};
      2'b01:   merged = {upper_src[W-1:HW], res[HW-1:0]};
      default: merged = res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= merged;
    end
  end

  assert_valid_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  assert_valid_drop_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  assert_byte_keep_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'b00 && policy == 2'b00) |=> out_data[W-1:BW] == $past(old_dst[W-1:BW]));
  assert_zero_upper_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size == 2'b00 && policy == 2'b10) |=> out_data[W-1:BW] == '0);
  assert_long_pass_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && size[1]) |=> out_data == $past(res));
  assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data));
endmodule

// File: tb/sim_subword_merge.sv
module sim_subword_merge;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic [31:0] res = '0, old_dst = '0, src1 = '0;
  logic [1:0] size = '0, policy = '0;
  logic [31:0] out_data;
  logic out_valid;

  int total = 0;
  int bad = 0;
  bit done = 0;
  logic [31:0] exp_data = '0;
  logic exp_valid = 1'b0;
  string exp_tag = "R1";

  always #5 clk = ~clk;

  subword_merge u0 (.clk(clk), .rst_n(rst_n), .in_valid(in_valid), .res(res),
    .old_dst(old_dst), .src1(src1), .size(size), .policy(policy),
    .out_data(out_data), .out_valid(out_valid));

  function automatic logic [31:0] model(logic [31:0] r, logic [31:0] o,
                                        logic [31:0] s, logic [1:0] sz, logic [1:0] p);
    longint unsigned n, lo, hi, up;
    if (sz >= 2) return r;
    n  = (sz == 0) ? 8 : 16;
    lo = (64'd1 << n) - 1;
    hi = 64'hFFFF_FFFF & ~lo;
    case (p)
      0: up = o;
      1: up = s;
      2: up = 0;
      default: up = r[n-1] ? 64'hFFFF_FFFF : 0;
    endcase
    return 32'((r & lo) | (up & hi));
  endfunction

  task automatic check_out();
    total++;
    if (out_valid !== exp_valid) begin
      bad++;
      $display("FAIL R2 valid: got %0b expected %0b", out_valid, exp_valid);
    end
    total++;
    if (out_data !== exp_data) begin
      bad++;
      $display("FAIL %s data: got %h expected %h", exp_tag, out_data, exp_data);
    end
  endtask

  task automatic step(logic v, logic [31:0] r, logic [31:0] o, logic [31:0] s,
                      logic [1:0] sz, logic [1:0] p);
    @(negedge clk);
    check_out();
    in_valid = v; res = r; old_dst = o; src1 = s; size = sz; policy = p;
    exp_valid = v;
    if (v) begin
      exp_data = model(r, o, s, sz, p);
      if (sz >= 2) exp_tag = "R8";
      else case (p)
        0: exp_tag = (sz == 0) ? "R3" : "R4";
        1: exp_tag = "R5";
        2: exp_tag = "R6";
        default: exp_tag = "R7";
      endcase
    end else exp_tag = "R9";
  endtask

  initial begin
    #200000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    in_valid = 1'b1; res = 32'hFFFF_FFFF; size = 2'b10;
    @(negedge clk);
    check_out();
    in_valid = 1'b0;
    rst_n = 1'b1;
    step(1, 32'h0000_0080, 32'hAABB_CCDD, 32'h1122_3344, 0, 0);
    step(1, 32'h0000_8001, 32'hAABB_CCDD, 32'h1122_3344, 1, 0);
    step(1, 32'h0000_007F, 32'hAABB_CCDD, 32'h1122_3344, 0, 1);
    step(1, 32'h0000_7FFF, 32'hAABB_CCDD, 32'h1122_3344, 1, 1);
    step(1, 32'hFFFF_FF80, 32'hAABB_CCDD, 32'h1122_3344, 0, 2);
    step(1, 32'hFFFF_8000, 32'hAABB_CCDD, 32'h1122_3344, 1, 2);
    step(1, 32'h0000_0080, 32'h0000_0000, 32'h0000_0000, 0, 3);
    step(1, 32'hFFFF_FF7F, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, 3);
    step(1, 32'h0000_8000, 32'h0000_0000, 32'h0000_0000, 1, 3);
    step(1, 32'hFFFF_7FFF, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 3);
    step(0, 32'h5555_5555, 32'h1234_5678, 32'h8765_4321, 0, 0);
    step(0, 32'hAAAA_AAAA, 32'h0F0F_0F0F, 32'hF0F0_F0F0, 1, 3);
    for (int p = 0; p < 4; p++) begin
      step(1, 32'hDEAD_BEEF + p, 32'h0BAD_F00D, 32'hCAFE_BABE, 2, 2'(p));
      step(1, 32'h1357_9BDF + p, 32'h0BAD_F00D, 32'hCAFE_BABE, 3, 2'(p));
    end
    for (int i = 0; i < 64; i++) begin
      logic [31:0] a = 32'h9E37_79B9 * (i + 1);
      step(i % 5 != 4, a, a ^ 32'hA5A5_5A5A, {a[15:0], a[31:16]},
           2'(i / 4), 2'(i));
    end
    step(0, '0, '0, '0, 0, 0);
    @(negedge clk);
    check_out();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule